// File: doc/BRIEF.md
# Carry-Free Binary Signed-Digit Adder

This block adds two radix-2 signed-digit numbers of `DIGITS` digits each. Every digit is one of -1, 0 or +1. The result has `DIGITS+1` signed digits. No carry ripples across the word: each sum digit depends only on its own digit pair and the two pairs just below it. The logic depth is therefore the same at every width.

Each position first splits its pair sum into a transfer digit for the next position and an interim digit for itself. Pairs that sum to +1 or -1 can be split in two ways. The block picks between them by looking one position down and asking whether either lower digit is -1. The choice ensures that interim digit plus incoming transfer always stays inside {-1,0,+1}. A control module derives per-position strobes (pair class and the lookahead flag), and a datapath module turns those strobes into digits. The datapath can also register the result behind one output stage.

Top module: `sdAdder`

## Requirements
- R1: Digit i of an operand occupies bits [2i+1:2i], with the upper bit as the negative half and the lower bit as the positive half. The digit value is lower minus upper, so 00 is 0, 01 is +1, 10 is -1 and 11 also reads as 0. The sum uses the same layout over `DIGITS+1` digits.
- R2: For every input, including inputs that contain code 11, the value of the sum digits equals the value of the first operand plus the value of the second.
- R3: No sum digit is ever coded 11. A zero sum digit is always 00.
- R4: A pair (+1,+1) sends transfer +1 upward and leaves interim 0. A pair (-1,-1) sends transfer -1 upward and leaves interim 0.
- R5: A pair whose digits sum to 0, i.e. (0,0), (+1,-1) or (-1,+1), sends transfer 0 and leaves interim 0.
- R6: A pair summing to +1 sends transfer +1 with interim -1 when neither digit one position lower is -1. Otherwise it sends transfer 0 with interim +1.
- R7: A pair summing to -1 sends transfer 0 with interim -1 when neither digit one position lower is -1. Otherwise it sends transfer -1 with interim +1.
- R8: Sum digit i (for i below `DIGITS`) is interim i plus the transfer arriving from position i-1, and it always lies in {-1,0,+1}. Sum digit `DIGITS` is the transfer leaving position `DIGITS-1`.
- R9: Position 0 has no incoming transfer. Its lookahead always reads as "no lower -1".
- R10: With `OUT_REG`=1, the sum for inputs present at a rising clock edge appears on the output after that edge and not before it. An active-low asynchronous reset clears every sum digit to 00. With `OUT_REG`=0, the sum follows the inputs combinationally.
- R11: Adding -9, written as digits -1 at 4, +1 at 3 and -1 at 0, to +29, written as +1 at 5, -1 at 1 and -1 at 0, yields a sum whose value is 20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Asynchronous active-low reset of the output stage |
| xDigits | input | 2*DIGITS | First operand, two bits per signed digit |
| yDigits | input | 2*DIGITS | Second operand, two bits per signed digit |
| sumDigits | output | 2*DIGITS+2 | Sum, two bits per signed digit, DIGITS+1 digits |

## Verification
The mixed-sign pairs are the heart of the block. Each one is driven at the top position with and without a -1 one position lower. A design that ignored the lookahead would leave a sum digit of +2 or -2, which shows up as a wrong digit or a stray 11 code. Code 11 on an input is exercised so that a decoder reading it as -1 or +1 would shift the value. Position 0 is tested on its own, because a lookahead that wrapped or read undefined bits would pick the wrong split there. An exhaustive sweep of all 4096 three-digit code pairs and random eight-digit pairs compare both the exact digit string and its value. A sampling check one cycle apart catches an output stage that leaks its input through or adds an extra cycle.

// File: rtl/sdaPkg.sv
package sdaPkg;

  localparam logic [1:0] SD_ZERO = 2'b00;
  localparam logic [1:0] SD_POS  = 2'b01;
  localparam logic [1:0] SD_NEG  = 2'b10;

  // Per-position strobes from control to datapath
  typedef struct packed {
    logic pairPlus2;
    logic pairMinus2;
    logic pairPlus1;
    logic pairMinus1;
    logic lowNeg;
  } sdaStrobe_t;

  function automatic logic signed [1:0] sdDecode(input logic [1:0] code);
    case (code)
      2'b01:   return 2'sd1;
      2'b10:   return -2'sd1;
      default: return 2'sd0;
    endcase
  endfunction

  function automatic logic [1:0] sdEncode(input logic signed [2:0] val);
    if (val == 3'sd1)       return SD_POS;
    else if (val == -3'sd1) return SD_NEG;
    else                    return SD_ZERO;
  endfunction

endpackage

// File: rtl/sdaControl.sv
module sdaControl
  import sdaPkg::*;
#(
  parameter int DIGITS = 8
) (
  input  logic [2*DIGITS-1:0]           xDigits,
  input  logic [2*DIGITS-1:0]           yDigits,
  output sdaStrobe_t [DIGITS-1:0]       strobes
);

  for (genvar i = 0; i < DIGITS; i++) begin : gPos
    logic signed [1:0] xVal;
    logic signed [1:0] yVal;
    logic signed [2:0] pairSum;
    logic              lowerNeg;
    sdaStrobe_t        strobe;

    assign xVal    = sdDecode(xDigits[2*i +: 2]);
    assign yVal    = sdDecode(yDigits[2*i +: 2]);
    assign pairSum = $signed({xVal[1], xVal}) + $signed({yVal[1], yVal});

    // Lookahead: position 0 has no lower neighbour
    if (i == 0) begin : gBase
      assign lowerNeg = 1'b0;
    end else begin : gLook
      assign lowerNeg = (xDigits[2*(i-1) +: 2] == SD_NEG) ||
                        (yDigits[2*(i-1) +: 2] == SD_NEG);
    end

    always_comb begin
      strobe.pairPlus2  = (pairSum == 3'sd2);
      strobe.pairMinus2 = (pairSum == -3'sd2);
      strobe.pairPlus1  = (pairSum == 3'sd1);
      strobe.pairMinus1 = (pairSum == -3'sd1);
      strobe.lowNeg     = lowerNeg;
    end

    assign strobes[i] = strobe;
  end

endmodule

// File: rtl/sdaDatapath.sv
module sdaDatapath
  import sdaPkg::*;
#(
  parameter int DIGITS  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sdaStrobe_t [DIGITS-1:0] strobes,
  output logic [2*DIGITS+1:0]     sumDigits
);

  localparam int SUM_BITS = 2*DIGITS + 2;

  wire [SUM_BITS-1:0] transferBits;
  wire [SUM_BITS-1:0] combSum;

  assign transferBits[1:0] = 2'b00;

  for (genvar i = 0; i < DIGITS; i++) begin : gPos
    logic signed [1:0] tOut;
    logic signed [1:0] wOut;
    logic signed [1:0] tIn;
    logic signed [2:0] finalVal;
    logic signed [3:0] splitVal;
    logic signed [3:0] pairVal;

    always_comb begin
      tOut = 2'sd0;
      wOut = 2'sd0;
      if (strobes[i].pairPlus2) begin
        tOut = 2'sd1;
      end else if (strobes[i].pairMinus2) begin
        tOut = -2'sd1;
      end else if (strobes[i].pairPlus1) begin
        if (strobes[i].lowNeg) begin
          wOut = 2'sd1;
        end else begin
          tOut = 2'sd1;
          wOut = -2'sd1;
        end
      end else if (strobes[i].pairMinus1) begin
        if (strobes[i].lowNeg) begin
          tOut = -2'sd1;
          wOut = 2'sd1;
        end else begin
          wOut = -2'sd1;
        end
      end
    end

    assign transferBits[2*(i+1) +: 2] = tOut;
    assign tIn      = $signed(transferBits[2*i +: 2]);
    assign finalVal = $signed({wOut[1], wOut}) + $signed({tIn[1], tIn});
    assign combSum[2*i +: 2] = sdEncode(finalVal);

    // Checker views: split value versus pair class
    assign splitVal = $signed({tOut[1], tOut, 1'b0}) + $signed({wOut[1], wOut[1], wOut});
    always_comb begin
      pairVal = 4'sd0;
      if (strobes[i].pairPlus2)       pairVal = 4'sd2;
      else if (strobes[i].pairMinus2) pairVal = -4'sd2;
      else if (strobes[i].pairPlus1)  pairVal = 4'sd1;
      else if (strobes[i].pairMinus1) pairVal = -4'sd1;
    end

    AST_PAIR_CONSERVE: assert property (@(posedge clk) disable iff (!rstN)
      splitVal == pairVal);                                           // R5
    AST_PLUS2_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].pairPlus2 |-> (tOut == 2'sd1 && wOut == 2'sd0));     // R4
    AST_MINUS2_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].pairMinus2 |-> (tOut == -2'sd1 && wOut == 2'sd0));   // R4
    AST_NO_LOWNEG_ROOM: assert property (@(posedge clk) disable iff (!rstN)
      !strobes[i].lowNeg |-> (wOut != 2'sd1));                        // R6
    AST_LOWNEG_ROOM: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].lowNeg |-> (wOut != -2'sd1));                        // R7
    AST_FINAL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      (finalVal >= -3'sd1) && (finalVal <= 3'sd1));                   // R8
  end

  // Top digit is the transfer out of the last position
  assign combSum[SUM_BITS-1 -: 2] =
    sdEncode($signed({transferBits[SUM_BITS-1], transferBits[SUM_BITS-1 -: 2]}));

  if (OUT_REG) begin : gReg
    logic [SUM_BITS-1:0] sumReg;
    logic                primed;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sumReg <= '0;
        primed <= 1'b0;
      end else begin
        sumReg <= combSum;
        primed <= 1'b1;
      end
    end

    assign sumDigits = sumReg;

    AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
      primed |-> (sumDigits == $past(combSum)));                      // R10
  end else begin : gComb
    assign sumDigits = combSum;
  end

  logic [DIGITS:0] code11;
  for (genvar k = 0; k <= DIGITS; k++) begin : gCode
    assign code11[k] = (sumDigits[2*k +: 2] == 2'b11);
  end

  AST_NO_CODE11: assert property (@(posedge clk) disable iff (!rstN)
    code11 == '0);                                                    // R3

endmodule

// File: rtl/sdAdder.sv
module sdAdder
  import sdaPkg::*;
#(
  parameter int DIGITS  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2*DIGITS-1:0]   xDigits,
  input  logic [2*DIGITS-1:0]   yDigits,
  output logic [2*DIGITS+1:0]   sumDigits
);

  sdaStrobe_t [DIGITS-1:0] strobes;

  sdaControl #(.DIGITS(DIGITS)) uControl (
    .xDigits (xDigits),
    .yDigits (yDigits),
    .strobes (strobes)
  );

  sdaDatapath #(.DIGITS(DIGITS), .OUT_REG(OUT_REG)) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sumDigits (sumDigits)
  );

endmodule

// File: tb/tb_sdAdder.sv
module tb_sdAdder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] xWide = '0;
  logic [15:0] yWide = '0;
  logic [17:0] sumWide;
  logic [5:0]  xSmall = '0;
  logic [5:0]  ySmall = '0;
  logic [7:0]  sumSmall;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdAdder #(.DIGITS(8), .OUT_REG(1'b1)) dut (
    .clk(clk), .rstN(rstN), .xDigits(xWide), .yDigits(yWide), .sumDigits(sumWide));

  sdAdder #(.DIGITS(3), .OUT_REG(1'b0)) dutSmall (
    .clk(clk), .rstN(rstN), .xDigits(xSmall), .yDigits(ySmall), .sumDigits(sumSmall));

  function automatic int dec(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? -1 : 0;
  endfunction

  function automatic logic [17:0] put(input logic [17:0] v, input int pos, input int val);
    logic [17:0] r = v;
    r[2*pos +: 2] = (val == 1) ? 2'b01 : (val == -1) ? 2'b10 : (val == 0) ? 2'b00 : 2'b11;
    return r;
  endfunction

  function automatic int sdValue(input logic [17:0] v, input int nd);
    int acc = 0;
    for (int i = 0; i < nd; i++) acc += dec(v[2*i +: 2]) * (1 << i);
    return acc;
  endfunction

  // Reference built from the split rules of R4..R9
  function automatic logic [17:0] refAdd(input logic [15:0] x, input logic [15:0] y, input int n);
    int t [9];
    int w [8];
    logic [17:0] r = '0;
    t[0] = 0;
    for (int i = 0; i < n; i++) begin
      int ps = dec(x[2*i +: 2]) + dec(y[2*i +: 2]);
      bit lowNeg = 1'b0;
      if (i > 0) lowNeg = (x[2*i-2 +: 2] == 2'b10) || (y[2*i-2 +: 2] == 2'b10);
      case (ps)
        2:  begin t[i+1] = 1;  w[i] = 0; end
        -2: begin t[i+1] = -1; w[i] = 0; end
        1:  begin t[i+1] = lowNeg ? 0 : 1;   w[i] = lowNeg ? 1 : -1; end
        -1: begin t[i+1] = lowNeg ? -1 : 0;  w[i] = lowNeg ? 1 : -1; end
        default: begin t[i+1] = 0; w[i] = 0; end
      endcase
    end
    for (int i = 0; i < n; i++) r = put(r, i, w[i] + t[i]);
    r = put(r, n, t[n]);
    return r;
  endfunction

  task automatic checkVec(input string req, input logic [17:0] act, input logic [17:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkInt(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic applyWide(input string req, input logic [15:0] x, input logic [15:0] y,
                           input logic [17:0] exp);
    @(negedge clk);
    xWide = x;
    yWide = y;
    @(negedge clk);
    checkVec(req, sumWide, exp);
  endtask

  task automatic testReset();
    xWide = 16'h5555;
    yWide = 16'h1111;
    @(negedge clk);
    @(negedge clk);
    checkVec("R10 reset clears sum", sumWide, '0);
    rstN = 1'b1;
  endtask

  task automatic testPairRules();
    logic [17:0] e;
    e = put('0, 8, 1);
    applyWide("R4 (+1,+1) top", put('0, 7, 1), put('0, 7, 1), e);
    e = put('0, 8, -1);
    applyWide("R4 (-1,-1) top", put('0, 7, -1), put('0, 7, -1), e);
    applyWide("R5 (+1,-1) top", put('0, 7, 1), put('0, 7, -1), '0);
    applyWide("R5 (0,0)", '0, '0, '0);
    e = put(put('0, 8, 1), 7, -1);
    applyWide("R6 +1 pair, no lower -1", put('0, 7, 1), '0, e);
    e = put(put('0, 7, 1), 6, -1);
    applyWide("R6 +1 pair, lower -1", put(put('0, 7, 1), 6, -1), '0, e);
    e = put('0, 7, -1);
    applyWide("R7 -1 pair, no lower -1", put('0, 7, -1), '0, e);
    e = put(put(put('0, 8, -1), 7, 1), 6, -1);
    applyWide("R7 -1 pair, lower -1", put('0, 7, -1), put('0, 6, -1), e);
    // Code 11 reads as zero: (11,+1) behaves as (0,+1)
    e = put(put('0, 8, 1), 7, -1);
    applyWide("R1 code 11 is zero", 16'hC000, put('0, 7, 1), e);
    // Code 11 in the lower pair must not count as -1
    e = put(put('0, 8, 1), 7, -1);
    applyWide("R1 code 11 not a lower -1", put('0, 7, 1) | 18'h3000, '0, e);
  endtask

  task automatic testPositionZero();
    xSmall = 6'b000001; ySmall = '0; #1;
    checkVec("R9 +1 at position 0", {10'b0, sumSmall}, put(put('0, 1, 1), 0, -1));
    xSmall = 6'b000110; ySmall = '0; #1;
    checkVec("R9 -1 at position 0 lookahead", {10'b0, sumSmall}, put(put('0, 1, 1), 0, -1));
  endtask

  task automatic testExample();
    logic [17:0] xs;
    logic [17:0] ys;
    xs = put(put(put('0, 4, -1), 3, 1), 0, -1);
    ys = put(put(put('0, 5, 1), 1, -1), 0, -1);
    checkInt("R11 operand -9", sdValue(xs, 8), -9);
    checkInt("R11 operand +29", sdValue(ys, 8), 29);
    applyWide("R11 digits", xs[15:0], ys[15:0], refAdd(xs[15:0], ys[15:0], 8));
    checkInt("R11 sum value", sdValue(sumWide, 9), 20);
  endtask

  task automatic testExhaustive();
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        logic [17:0] act;
        bit bad11;
        xSmall = a[5:0];
        ySmall = b[5:0];
        #1;
        act = {10'b0, sumSmall};
        checkVec("R8 digit string", act, refAdd({10'b0, a[5:0]}, {10'b0, b[5:0]}, 3));
        checkInt("R2 sum value", sdValue(act, 4),
                 sdValue({12'b0, a[5:0]}, 3) + sdValue({12'b0, b[5:0]}, 3));
        bad11 = 1'b0;
        for (int k = 0; k < 4; k++) if (act[2*k +: 2] == 2'b11) bad11 = 1'b1;
        checkInt("R3 no code 11", int'(bad11), 0);
      end
    end
  endtask

  task automatic testRandom();
    for (int j = 0; j < 3000; j++) begin
      logic [15:0] x = 16'($urandom);
      logic [15:0] y = 16'($urandom);
      applyWide("R2 random digits", x, y, refAdd(x, y, 8));
      checkInt("R2 random value", sdValue(sumWide, 9),
               sdValue({2'b0, x}, 8) + sdValue({2'b0, y}, 8));
    end
  endtask

  task automatic testLatency();
    logic [17:0] oldSum;
    applyWide("R10 setup", put('0, 2, 1), put('0, 2, 1), put('0, 3, 1));
    oldSum = sumWide;
    @(negedge clk);
    xWide = put('0, 5, -1);
    yWide = put('0, 5, -1);
    #1;
    checkVec("R10 no early change", sumWide, oldSum);
    @(negedge clk);
    checkVec("R10 after one edge", sumWide, put('0, 6, -1));
  endtask

  initial begin
    testReset();
    testPairRules();
    testPositionZero();
    testExample();
    testExhaustive();
    testRandom();
    testLatency();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog R10: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule